// File: doc/BRIEF.md
# Hotspot Bank Controller with Shared Serial-Data Bit

This block sits on a cartridge bus of 13 address lines and picks which of eight 4K ROM banks answers each read. It selects banks through "hotspots": reads that land in certain address windows change the bank number as a side effect. The same reads also produce the serial clock of an I2C memory. The lowest bank bit doubles as the open-drain serial data line. The memory can therefore hold that bit low and force the even bank of the selected pair.

A read decides three things: whether the clock pulses for one bus cycle, what the low bank bit becomes, and whether the two upper bank bits are loaded. A change to the low bit is queued and applied one bus cycle later. Because of this, a page-crossing access from the 0x04xx window into the 0x05xx window changes the data line while the clock is held high. Decoding happens only on bus cycles marked by a cycle-valid strobe.

Top module: `hotspot_bank_ctrl`

## Requirements
- R1: After reset, `bank` is 0, `sck` is low and `sda_oe` is 1, because the low register bit is 0 and the line is pulled low.
- R2: `bank[0]` equals the low register bit ANDed with `sda_in`. When an external device holds the line low, `bank[0]` reads 0 whatever the register holds.
- R3: `sck` is high for exactly one valid bus cycle after a read in 0x1FF0–0x1FFB, 0x0400–0x04FF or 0x0800–0x0FFF. A read in 0x0500–0x05FF extends an existing high phase. All other reads leave `sck` low.
- R4: A low-bit request from a read becomes visible in the register one valid bus cycle after the cycle in which `sck` first reflects that read.
- R5: 0x1FF0–0x1FF7 request low bit 1 and 0x1FF8–0x1FFB request low bit 0, both with a clock pulse. 0x1FFC–0x1FFF clear the upper bank bits at once and request low bit 0, with no clock pulse.
- R6: A read in 0x0800–0x0FFF requests as the low bit the address bit whose index is A10:A8, so 0x08xx takes A0 and 0x0Fxx takes A7.
- R7: A read in 0x0400–0x04FF requests A5 as the low bit. A read in 0x05xx that directly follows it keeps `sck` high while the new low bit appears.
- R8: A read in 0x0600–0x06FF loads A7:A6 into `bank[2:1]` at once and requests A5 as the low bit. A read in 0x0700–0x07FF requests A7. Neither read pulses the clock.
- R9: Reads in 0x1000–0x1FEF and in 0x0000–0x03FF change no bank bit and leave `sck` low.
- R10: While `cyc_valid` is low, the bank, the pending request and `sck` all hold.
- R11: `sda_oe` is 1 exactly when the low register bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_valid | input | 1 | Marks the clock edge that ends a bus cycle |
| addr | input | 13 | Bus address A12:A0 |
| sda_in | input | 1 | Sensed level of the serial data line |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |
| sck | output | 1 | Serial clock to the memory |
| bank | output | 3 | Effective ROM bank number |

## Verification
The bench builds the block with its default widths: a 13-bit address and a 3-bit bank. With these widths every hotspot window, including the eight copy-bit pages and the bank-load page, can be reached by biased random addresses. Random stimulus also drops the valid strobe and has the modelled device pull the line low, which exercises the wired-AND path. Directed sequences cover the page crossing from 0x04xx into 0x05xx, bank loads and holds.

// File: rtl/hotspot_bank_ctrl.sv
module hotspot_bank_ctrl #(
  parameter int ADDR_W = 13,
  parameter int BANK_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_valid,
  input  logic [ADDR_W-1:0] addr,
  input  logic              sda_in,
  output logic              sda_oe,
  output logic              sck,
  output logic [BANK_W-1:0] bank
);
  localparam int HI_W = BANK_W - 1;

  logic [HI_W-1:0] hi_q;
  logic            lo_q;
  logic            pend_q;
  logic            pend_val_q;
  logic            sck_q;

  logic            in_top;
  logic            in_low;
  logic [3:0]      page;
  logic            clk_hit;
  logic            hold_hit;
  logic            req;
  logic            req_val;
  logic            hi_ld;
  logic [HI_W-1:0] hi_val;

  assign in_top = addr[12] && (addr[11:4] == 8'hFF);
  assign in_low = !addr[12];
  assign page   = addr[11:8];

  always_comb begin
    clk_hit  = 1'b0;
    hold_hit = 1'b0;
    req      = 1'b0;
    req_val  = 1'b0;
    hi_ld    = 1'b0;
    hi_val   = '0;
    if (in_top) begin
      if (!addr[3]) begin
        clk_hit = 1'b1;
        req     = 1'b1;
        req_val = 1'b1;
      end else if (!addr[2]) begin
        clk_hit = 1'b1;
        req     = 1'b1;
      end else begin
        hi_ld   = 1'b1;
        req     = 1'b1;
      end
    end else if (in_low) begin
      if (page[3]) begin
        clk_hit = 1'b1;
        req     = 1'b1;
        req_val = addr[page[2:0]];
      end else begin
        case (page[2:0])
          3'd4: begin
            clk_hit = 1'b1;
            req     = 1'b1;
            req_val = addr[5];
          end
          3'd5: hold_hit = 1'b1;
          3'd6: begin
            hi_ld   = 1'b1;
            hi_val  = addr[5+HI_W:6];
            req     = 1'b1;
            req_val = addr[5];
          end
          3'd7: begin
            req     = 1'b1;
            req_val = addr[7];
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q       <= '0;
      lo_q       <= 1'b0;
      pend_q     <= 1'b0;
      pend_val_q <= 1'b0;
      sck_q      <= 1'b0;
    end else if (cyc_valid) begin
      if (pend_q) lo_q <= pend_val_q;
      pend_q     <= req;
      pend_val_q <= req_val;
      sck_q      <= clk_hit || (hold_hit && sck_q);
      if (hi_ld) hi_q <= hi_val;
    end
  end

  assign sck    = sck_q;
  assign sda_oe = !lo_q;
  assign bank   = {hi_q, lo_q & sda_in};
endmodule

module hotspot_bank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cyc_valid,
  input logic [12:0] addr,
  input logic        sda_in,
  input logic        sda_oe,
  input logic        sck,
  input logic [2:0]  bank
);
  // R2
  wired_and_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sda_in |-> !bank[0]);

  // R11
  oe_low_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sda_oe && bank[0]));

  // R8
  page6_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && addr[12:8] == 5'h06) |=> (bank[2:1] == $past(addr[7:6]) && !sck));

  // R9
  plain_rom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && addr[12] && addr[11:4] != 8'hFF) |=> (!sck && $stable(bank[2:1])));

  // R3
  clock_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && (addr[12:11] == 2'b01 || addr[12:8] == 5'h04)) |=> sck);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_valid |=> ($stable(sck) && $stable(sda_oe) && $stable(bank[2:1])));

  // R5
  top_bank0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && addr[12:2] == 11'h7FF) |=> (bank[2:1] == 2'b00 && !sck));
endmodule

bind hotspot_bank_ctrl hotspot_bank_chk i_chk (
  .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .addr(addr),
  .sda_in(sda_in), .sda_oe(sda_oe), .sck(sck), .bank(bank)
);

// File: tb/test_hotspot_bank_ctrl.sv
module test_hotspot_bank_ctrl;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cyc_valid = 1'b0;
  logic [12:0] addr = '0;
  logic        dev_low = 1'b0;
  logic        sda_in;
  logic        sda_oe;
  logic        sck;
  logic [2:0]  bank;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  logic       m_lo, m_sck, m_pend, m_pv;
  logic [1:0] m_hi;
  string      m_tag;

  assign sda_in = !sda_oe && !dev_low;

  always #(CLK_P/2) clk = ~clk;

  hotspot_bank_ctrl i_hotspot_bank_ctrl (
    .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .addr(addr),
    .sda_in(sda_in), .sda_oe(sda_oe), .sck(sck), .bank(bank)
  );

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (addr %h)", tag, act, exp, addr);
    end
  endtask

  function automatic string dec_class(input logic [12:0] a);
    if (a[12] && a[11:4] == 8'hFF) return "R5";
    if (a[12] || a[11:10] == 2'b00) return "R9";
    if (a[11]) return "R6";
    if (a[10:8] == 3'd4 || a[10:8] == 3'd5) return "R7";
    return "R8";
  endfunction

  task automatic model(input logic [12:0] a, input logic v);
    logic ck, hold, rq, rv, hl;
    logic [1:0] hv;
    if (!v) begin
      m_tag = "R10";
      return;
    end
    m_tag = dec_class(a);
    ck = 0; hold = 0; rq = 0; rv = 0; hl = 0; hv = 0;
    if (a[12] && a[11:4] == 8'hFF) begin
      if (a[3:0] < 4'd8)       begin ck = 1; rq = 1; rv = 1; end
      else if (a[3:0] < 4'd12) begin ck = 1; rq = 1; rv = 0; end
      else                     begin hl = 1; hv = 0; rq = 1; rv = 0; end
    end else if (!a[12]) begin
      if (a[11]) begin ck = 1; rq = 1; rv = a[int'(a[10:8])]; end
      else if (a[10:8] == 3'd4) begin ck = 1; rq = 1; rv = a[5]; end
      else if (a[10:8] == 3'd5) hold = 1;
      else if (a[10:8] == 3'd6) begin hl = 1; hv = a[7:6]; rq = 1; rv = a[5]; end
      else if (a[10:8] == 3'd7) begin rq = 1; rv = a[7]; end
    end
    if (m_pend) m_lo = m_pv;
    m_pend = rq;
    m_pv   = rv;
    m_sck  = ck | (hold & m_sck);
    if (hl) m_hi = hv;
  endtask

  task automatic cyc(input logic [12:0] a, input logic v, input logic dl);
    @(negedge clk);
    addr = a; cyc_valid = v; dev_low = dl;
    @(posedge clk);
    model(a, v);
    #1;
    chk(sck, m_sck, "R3");
    chk(bank[0], m_lo & !dl, dl ? "R2" : "R4");
    chk(bank[2:1], m_hi, m_tag);
    chk(sda_oe, !m_lo, "R11");
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000 && !done) begin
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 200000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    m_lo = 0; m_sck = 0; m_pend = 0; m_pv = 0; m_hi = 0; m_tag = "R1";
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk(bank, 0, "R1"); chk(sck, 0, "R1"); chk(sda_oe, 1, "R1");

    // R8 full bank load through 06xx: 0x06E0 -> bank 7
    cyc(13'h06E0, 1, 0);
    chk(bank[2:1], 3, "R8");
    cyc(13'h0000, 1, 0);
    chk(bank, 7, "R8");
    // R2 device pull forces even bank
    cyc(13'h0000, 1, 1);
    chk(bank, 6, "R2");
    // R10 strobe low: no change
    cyc(13'h1FFC, 0, 0);
    chk(bank, 7, "R10");
    // R5 bank zero
    cyc(13'h1FFC, 1, 0);
    cyc(13'h0000, 1, 0);
    chk(bank, 0, "R5");
    // R7 page cross 04xx into 05xx
    cyc(13'h0420, 1, 0);
    chk(sck, 1, "R7"); chk(bank[0], 0, "R7");
    cyc(13'h0520, 1, 0);
    chk(sck, 1, "R7"); chk(bank[0], 1, "R7");
    cyc(13'h0000, 1, 0);
    chk(sck, 0, "R3");
    // R6 0x0Fxx copies A7
    cyc(13'h0F7F, 1, 0);
    cyc(13'h0000, 1, 0);
    chk(bank[0], 0, "R6");
    cyc(13'h0B08, 1, 0);
    cyc(13'h0000, 1, 0);
    chk(bank[0], 1, "R6");
    // R9 plain ROM read
    cyc(13'h1234, 1, 0);
    chk(sck, 0, "R9");

    for (int i = 0; i < 3000; i++) begin
      logic [12:0] a;
      int r;
      r = $urandom % 9;
      case (r)
        0: a = 13'h1FF0 | 13'($urandom % 16);
        1: a = 13'h0800 | 13'($urandom % 2048);
        2: a = 13'h0400 | 13'($urandom % 256);
        3: a = 13'h0500 | 13'($urandom % 256);
        4: a = 13'h0600 | 13'($urandom % 256);
        5: a = 13'h0700 | 13'($urandom % 256);
        6: a = 13'h1000 | 13'($urandom % 4080);
        7: a = 13'($urandom % 1024);
        default: a = 13'($urandom);
      endcase
      cyc(a, ($urandom % 8) != 0, ($urandom % 6) == 0);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule